// File: doc/BRIEF.md
# All-to-All Compartment Exchange Engine

This block copies data across an array of `N_MOD` modules. Each module owns a communication area in its local memory. That area is divided into `N_MOD` compartments of equal size, one compartment for each module. Before the engine runs, every module writes its outgoing packet into the compartment that carries its own index. On a start command the engine copies module *i*'s compartment *i* into compartment *i* of every other module. The compartment number in a receiver's storage therefore identifies the sender. When the copy ends, each module reads the compartments of the peers it needs. Filling and draining the compartments are the modules' own work.

The engine has one single-port synchronous memory interface per module. Each read returns data a fixed `RD_LAT` cycles after it is issued. The engine copies one sender at a time. It reads one word per cycle from the sender and writes that word to all other modules in the same cycle. Before it moves to the next sender, it waits for the read pipeline to drain, so one module port never carries a read and a write in the same cycle. The compartment base address and the compartment size are inputs that the engine samples when it accepts a start. The engine drives the memory ports only while `busy` is high.

Top module: `cmpt_xchg_engine`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `busy`, `done` and `err` are low and no `mem_en` bit is set.
- R2: A start with `cfg_size` equal to zero is rejected. `err` is high for exactly one cycle, on the cycle after start. `busy` stays low and no memory write takes place.
- R3: A start with `cfg_base + N_MOD*cfg_size` greater than `MEM_DEPTH` is rejected in the same way as in R2. A start whose end address equals `MEM_DEPTH` exactly is accepted.
- R4: Compartment *k* covers addresses `cfg_base + k*cfg_size` up to `cfg_base + (k+1)*cfg_size - 1`. After an accepted exchange, every module *j* ≠ *k* holds in compartment *k* the words that module *k* held in its compartment *k* at start. Writes are issued sender by sender in ascending index order, word by word in ascending address order, and go to all receivers of one word in the same cycle.
- R5: Every word that R4 does not name keeps its value. This covers each module's own compartment and every address outside the compartment region.
- R6: After an accepted start, `busy` is high for exactly `N_MOD*(cfg_size+RD_LAT)` consecutive cycles, starting on the cycle after start. `done` is high for one cycle, on the cycle after the last write, and `busy` is low in that cycle.
- R7: No `mem_en` bit is high in a cycle in which `busy` is low.
- R8: A start raised while `busy` is high has no effect. This holds even when `cfg_base` or `cfg_size` change at the same time: the running exchange keeps its sampled configuration, and no `err` pulse is produced.
- R9: A module's port issues reads only inside that module's own compartment. It receives writes only inside the compartments of other modules. No more than one port reads in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request an exchange; sampled while idle |
| cfg_base_i | input | ADDR_W | Address of compartment 0 |
| cfg_size_i | input | SIZE_W | Words per compartment |
| busy_o | output | 1 | Exchange in progress; memory ports are held by the engine |
| done_o | output | 1 | One-cycle pulse after the last write |
| err_o | output | 1 | One-cycle pulse when a start is rejected |
| mem_en_o | output | N_MOD | Per-module port enable |
| mem_we_o | output | N_MOD | Per-module write strobe (read when low) |
| mem_addr_o | output | N_MOD*ADDR_W | Per-module address, module m at bits m*ADDR_W |
| mem_wdata_o | output | N_MOD*DATA_W | Per-module write data |
| mem_rdata_i | input | N_MOD*DATA_W | Per-module read data, valid RD_LAT cycles after the read |

## Verification
The bench builds the engine with four modules, a 64-word memory (`ADDR_W` 6), 16-bit data and `RD_LAT` set to 2. Setting `RD_LAT` to 2 makes the drain gap between senders more than one cycle long and gives the tag pipeline more than one stage. With a 64-word memory, a compartment size of 16 with base 0, or of 1 with base 60, ends exactly at the top of memory, while slightly larger settings overflow. Both sides of the R3 limit are therefore checked. A start repeated in the middle of a run, carrying a different size, checks that the engine keeps the configuration it sampled.

// File: rtl/cmpt_xchg_pkg.sv
// Package: types shared by the compartment exchange engine.
// Assumes nothing beyond IEEE 1800-2017.
package cmpt_xchg_pkg;

    // Sequencer phases: idle, issuing sender reads, waiting for in-flight writes.
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_state_e;

    // Width of an index that selects one of n items (at least one bit).
    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cmpt_cfg_check.sv
// Module: cmpt_cfg_check
// Decides whether a requested layout is usable: the compartment size must be
// non-zero and N_MOD compartments starting at base must fit in MEM_DEPTH.
// Assumes: purely combinational; the result is consumed only while idle.
module cmpt_cfg_check #(
    parameter int N_MOD     = 4,
    parameter int ADDR_W    = 8,
    parameter int SIZE_W    = 8,
    parameter int MEM_DEPTH = 256
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              cfg_ok_o
);
    localparam int SUM_W = ADDR_W + SIZE_W + $clog2(N_MOD) + 2;

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] region_end;

    // Compute the end of the compartment region and compare it with the depth.
    always_comb begin
        span       = SUM_W'(size_i) * SUM_W'(N_MOD);
        region_end = SUM_W'(base_i) + span;
        cfg_ok_o   = (size_i != '0) && (region_end <= SUM_W'(MEM_DEPTH));
    end

endmodule

// File: rtl/cmpt_addr_seq.sv
// Module: cmpt_addr_seq
// Control sequencer. It accepts or rejects a start, then walks the senders in
// ascending order and issues one read per cycle over the sender's compartment.
// After each sender it waits until the last tagged write leaves the pipeline.
// Assumes: compartments are contiguous, so one running address covers all.
module cmpt_addr_seq
    import cmpt_xchg_pkg::*;
#(
    parameter int N_MOD  = 4,
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              start_i,
    input  logic              cfg_ok_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              pipe_eos_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              rd_valid_o,
    output logic [SEL_W-1:0]  rd_sender_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_eos_o
);
    seq_state_e        state_q;
    logic [SEL_W-1:0]  sender_q;
    logic [SIZE_W-1:0] word_q;
    logic [SIZE_W-1:0] size_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              err_q;
    logic              last_word;
    logic              last_sender;

    // Decode the end of the current compartment and the final sender.
    always_comb begin
        last_word   = (word_q == size_q - SIZE_W'(1));
        last_sender = (sender_q == SEL_W'(N_MOD - 1));
    end

    // Phase register, counters and the one-cycle status pulses.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q  <= SQ_IDLE;
            sender_q <= '0;
            word_q   <= '0;
            size_q   <= '0;
            addr_q   <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        if (cfg_ok_i) begin
                            state_q  <= SQ_READ;
                            sender_q <= '0;
                            word_q   <= '0;
                            size_q   <= size_i;
                            addr_q   <= base_i;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                SQ_READ: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    if (last_word) begin
                        word_q  <= '0;
                        state_q <= SQ_DRAIN;
                    end else begin
                        word_q <= word_q + SIZE_W'(1);
                    end
                end
                SQ_DRAIN: begin
                    if (pipe_eos_i) begin
                        if (last_sender) begin
                            state_q <= SQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            sender_q <= sender_q + SEL_W'(1);
                            state_q  <= SQ_READ;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive the read request and status outputs.
    always_comb begin
        busy_o      = (state_q != SQ_IDLE);
        rd_valid_o  = (state_q == SQ_READ);
        rd_sender_o = sender_q;
        rd_addr_o   = addr_q;
        rd_eos_o    = (state_q == SQ_READ) && last_word;
        done_o      = done_q;
        err_o       = err_q;
    end

    // A rejected start leaves the engine idle (R2, R3).
    assert_reject_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        err_o |-> !busy_o);

    // Completion follows the final end-of-sender write from the pipeline (R6).
    assert_done_after_eos_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_o |-> $past(pipe_eos_i));

endmodule

// File: rtl/cmpt_rd_pipe.sv
// Module: cmpt_rd_pipe
// Delay line that carries each read's tag (sender, address, end-of-sender)
// for LAT cycles, so the tag lines up with the read data returned by memory.
// Assumes: memory read latency is fixed and equal to LAT (LAT >= 1).
module cmpt_rd_pipe #(
    parameter int LAT    = 1,
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              rd_valid_i,
    input  logic [SEL_W-1:0]  rd_sender_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_eos_i,
    input  logic              busy_i,
    output logic              wr_valid_o,
    output logic [SEL_W-1:0]  wr_sender_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              wr_eos_o
);
    typedef struct packed {
        logic              vld;
        logic              eos;
        logic [SEL_W-1:0]  snd;
        logic [ADDR_W-1:0] adr;
    } tag_t;

    tag_t stage_q [LAT];
    tag_t in_tag;

    // Bundle the issued read into a tag.
    always_comb begin
        in_tag.vld = rd_valid_i;
        in_tag.eos = rd_eos_i;
        in_tag.snd = rd_sender_i;
        in_tag.adr = rd_addr_i;
    end

    // Shift tags one stage per cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= in_tag;
            for (int i = 1; i < LAT; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    // Present the oldest tag as the write request.
    always_comb begin
        wr_valid_o  = stage_q[LAT-1].vld;
        wr_eos_o    = stage_q[LAT-1].vld && stage_q[LAT-1].eos;
        wr_sender_o = stage_q[LAT-1].snd;
        wr_addr_o   = stage_q[LAT-1].adr;
    end

    // A write can only leave the pipeline while an exchange runs (R7).
    assert_write_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        wr_valid_o |-> busy_i);

endmodule

// File: rtl/cmpt_port_mux.sv
// Module: cmpt_port_mux
// Drives the per-module memory ports. The current sender's port gets the read,
// and every other port gets the write of the word returned by the sender's port.
// Assumes: the sequencer never overlaps a sender's reads with writes into it.
module cmpt_port_mux #(
    parameter int N_MOD  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_n_i,
    input  logic                      busy_i,
    input  logic                      rd_valid_i,
    input  logic [SEL_W-1:0]          rd_sender_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    input  logic                      wr_valid_i,
    input  logic [SEL_W-1:0]          wr_sender_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [N_MOD*DATA_W-1:0]   mem_rdata_i,
    output logic [N_MOD-1:0]          mem_en_o,
    output logic [N_MOD-1:0]          mem_we_o,
    output logic [N_MOD*ADDR_W-1:0]   mem_addr_o,
    output logic [N_MOD*DATA_W-1:0]   mem_wdata_o
);
    logic [DATA_W-1:0] fwd_data;

    // Select the word returned by the sender whose tag is at the pipe output.
    always_comb fwd_data = mem_rdata_i[wr_sender_i*DATA_W +: DATA_W];

    for (genvar m = 0; m < N_MOD; m++) begin : g_port
        logic rd_hit;
        logic wr_hit;

        assign rd_hit = rd_valid_i && (rd_sender_i == SEL_W'(m));
        assign wr_hit = wr_valid_i && (wr_sender_i != SEL_W'(m));

        assign mem_en_o[m]                      = rd_hit | wr_hit;
        assign mem_we_o[m]                      = wr_hit;
        assign mem_addr_o[m*ADDR_W +: ADDR_W]   = wr_hit ? wr_addr_i : rd_addr_i;
        assign mem_wdata_o[m*DATA_W +: DATA_W]  = fwd_data;

        // A single port never carries a read and a write in one cycle (R9).
        assert_no_rw_clash_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            !(rd_hit && wr_hit));
    end

    // Ports are only used while the exchange holds them (R7).
    assert_enable_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (|mem_en_o) |-> busy_i);

endmodule

// File: rtl/cmpt_xchg_engine.sv
// Module: cmpt_xchg_engine (top)
// All-to-all compartment copy engine. Module k's compartment k is copied into
// compartment k of every other module, one sender after another.
// Assumes: one single-port synchronous memory per module with a read latency of
// RD_LAT cycles; N_MOD >= 2; the modules do not touch their memories while busy.
module cmpt_xchg_engine
    import cmpt_xchg_pkg::*;
#(
    parameter int N_MOD     = 4,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SIZE_W    = 8,
    parameter int MEM_DEPTH = 2 ** ADDR_W,
    parameter int RD_LAT    = 1
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic                    start_i,
    input  logic [ADDR_W-1:0]       cfg_base_i,
    input  logic [SIZE_W-1:0]       cfg_size_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    err_o,
    output logic [N_MOD-1:0]        mem_en_o,
    output logic [N_MOD-1:0]        mem_we_o,
    output logic [N_MOD*ADDR_W-1:0] mem_addr_o,
    output logic [N_MOD*DATA_W-1:0] mem_wdata_o,
    input  logic [N_MOD*DATA_W-1:0] mem_rdata_i
);
    localparam int SEL_W = sel_width(N_MOD);

    logic              cfg_ok;
    logic              rd_valid;
    logic [SEL_W-1:0]  rd_sender;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_eos;
    logic              wr_valid;
    logic [SEL_W-1:0]  wr_sender;
    logic [ADDR_W-1:0] wr_addr;
    logic              wr_eos;
    logic [N_MOD-1:0]  rd_en_vec;

    cmpt_cfg_check #(
        .N_MOD(N_MOD), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MEM_DEPTH(MEM_DEPTH)
    ) u_cfg (
        .base_i(cfg_base_i), .size_i(cfg_size_i), .cfg_ok_o(cfg_ok)
    );

    cmpt_addr_seq #(
        .N_MOD(N_MOD), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .SEL_W(SEL_W)
    ) u_seq (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .start_i(start_i), .cfg_ok_i(cfg_ok),
        .base_i(cfg_base_i), .size_i(cfg_size_i), .pipe_eos_i(wr_eos),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .rd_valid_o(rd_valid), .rd_sender_o(rd_sender), .rd_addr_o(rd_addr),
        .rd_eos_o(rd_eos)
    );

    cmpt_rd_pipe #(
        .LAT(RD_LAT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_pipe (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .rd_valid_i(rd_valid),
        .rd_sender_i(rd_sender), .rd_addr_i(rd_addr), .rd_eos_i(rd_eos),
        .busy_i(busy_o), .wr_valid_o(wr_valid), .wr_sender_o(wr_sender),
        .wr_addr_o(wr_addr), .wr_eos_o(wr_eos)
    );

    cmpt_port_mux #(
        .N_MOD(N_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_mux (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .busy_i(busy_o),
        .rd_valid_i(rd_valid), .rd_sender_i(rd_sender), .rd_addr_i(rd_addr),
        .wr_valid_i(wr_valid), .wr_sender_i(wr_sender), .wr_addr_i(wr_addr),
        .mem_rdata_i(mem_rdata_i), .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    // Read enables seen at the ports, for the single-reader check.
    always_comb rd_en_vec = mem_en_o & ~mem_we_o;

    // Only the current sender's port reads in any cycle (R9).
    assert_single_reader_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $countones(rd_en_vec) <= 1);

endmodule

// File: tb/cmpt_xchg_engine_tb.sv
// Bench for cmpt_xchg_engine. A driver task queues every write it expects, and a
// monitor pops and compares the writes as the ports issue them. Memories are
// modelled with a RD_LAT-cycle read latency.
module cmpt_xchg_engine_tb;
    localparam int N      = 4;
    localparam int AW     = 6;
    localparam int DW     = 16;
    localparam int SW     = 6;
    localparam int DEPTH  = 64;
    localparam int LAT    = 2;

    typedef struct {
        int          mod;
        int          adr;
        logic [DW-1:0] dat;
    } wr_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [AW-1:0]     cfg_base = '0;
    logic [SW-1:0]     cfg_size = '0;
    logic              busy, done, err;
    logic [N-1:0]      mem_en, mem_we;
    logic [N*AW-1:0]   mem_addr;
    logic [N*DW-1:0]   mem_wdata;
    logic [N*DW-1:0]   mem_rdata;

    logic [DW-1:0] mem     [N][DEPTH];
    logic [DW-1:0] exp_img [N][DEPTH];
    logic [DW-1:0] rpipe   [N][LAT];

    wr_item_t exp_q [$];

    int compared = 0;
    int mismatched = 0;
    int busy_cnt, done_cnt, err_cnt, bad_en_cnt, bad_rng_cnt, done_busy_cnt;
    int cur_base, cur_size;
    bit monitor_on = 1'b0;

    always #2 clk = ~clk;

    cmpt_xchg_engine #(
        .N_MOD(N), .ADDR_W(AW), .DATA_W(DW), .SIZE_W(SW), .MEM_DEPTH(DEPTH), .RD_LAT(LAT)
    ) u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .start_i(start), .cfg_base_i(cfg_base),
        .cfg_size_i(cfg_size), .busy_o(busy), .done_o(done), .err_o(err),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
    );

    // Memory model: write on enable+we, read data after LAT cycles.
    always @(posedge clk) begin
        for (int m = 0; m < N; m++) begin
            if (mem_en[m] && mem_we[m]) mem[m][mem_addr[m*AW +: AW]] <= mem_wdata[m*DW +: DW];
            rpipe[m][0] <= mem[m][mem_addr[m*AW +: AW]];
            for (int k = 1; k < LAT; k++) rpipe[m][k] <= rpipe[m][k-1];
        end
    end
    always_comb for (int m = 0; m < N; m++) mem_rdata[m*DW +: DW] = rpipe[m][LAT-1];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare writes with the queue, count status and port usage.
    always @(negedge clk) begin
        if (monitor_on) begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (done && busy) done_busy_cnt++;
            if (err) err_cnt++;
            for (int m = 0; m < N; m++) begin
                if (mem_en[m]) begin
                    int a;
                    a = int'(mem_addr[m*AW +: AW]);
                    if (!busy) bad_en_cnt++;
                    if (!mem_we[m]) begin
                        if (a < cur_base + m*cur_size || a >= cur_base + (m+1)*cur_size)
                            bad_rng_cnt++;
                    end else begin
                        wr_item_t it;
                        if (a < cur_base || a >= cur_base + N*cur_size ||
                            (a >= cur_base + m*cur_size && a < cur_base + (m+1)*cur_size))
                            bad_rng_cnt++;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R4", "unexpected write to module", m, -1);
                        end else begin
                            it = exp_q.pop_front();
                            chk(it.mod == m && it.adr == a && it.dat == mem_wdata[m*DW +: DW],
                                "R4", "write stream (module/addr/data)",
                                longint'(m) * 65536 * 256 + longint'(a) * 65536 + longint'(mem_wdata[m*DW +: DW]),
                                longint'(it.mod) * 65536 * 256 + longint'(it.adr) * 65536 + longint'(it.dat));
                        end
                    end
                end
            end
        end
    end

    // Driver: preload memories, queue expected writes, run one exchange, check.
    task automatic run_xchg(input int base, input int size, input bit poke, input int seed);
        bit ok;
        int r4_bad, r5_bad, waited;
        ok = (size != 0) && (base + N*size <= DEPTH);
        for (int m = 0; m < N; m++)
            for (int a = 0; a < DEPTH; a++) begin
                mem[m][a]     = DW'(m * 16'h1357 + a * 16'h0101 + seed * 16'h2468);
                exp_img[m][a] = mem[m][a];
            end
        exp_q.delete();
        if (ok) begin
            for (int s = 0; s < N; s++)
                for (int w = 0; w < size; w++)
                    for (int r = 0; r < N; r++)
                        if (r != s) begin
                            wr_item_t it;
                            it.mod = r; it.adr = base + s*size + w;
                            it.dat = mem[s][base + s*size + w];
                            exp_q.push_back(it);
                            exp_img[r][it.adr] = it.dat;
                        end
        end
        cur_base = base; cur_size = size;
        busy_cnt = 0; done_cnt = 0; err_cnt = 0; bad_en_cnt = 0;
        bad_rng_cnt = 0; done_busy_cnt = 0;
        monitor_on = 1'b1;
        @(negedge clk);
        start = 1'b1; cfg_base = AW'(base); cfg_size = SW'(size);
        @(negedge clk);
        start = 1'b0;
        chk(busy == ok, ok ? "R6" : "R2", "busy on cycle after start", busy, ok);
        chk(err == !ok, ok ? "R8" : "R3", "err on cycle after start", err, !ok);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; cfg_size = '0; cfg_base = AW'(DEPTH - 1);
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        repeat (LAT + 3) @(negedge clk);
        monitor_on = 1'b0;
        chk(err_cnt == (ok ? 0 : 1), poke ? "R8" : "R2", "err pulse count", err_cnt, ok ? 0 : 1);
        chk(done_cnt == (ok ? 1 : 0), "R6", "done pulse count", done_cnt, ok ? 1 : 0);
        chk(done_busy_cnt == 0, "R6", "done while busy", done_busy_cnt, 0);
        chk(busy_cnt == (ok ? N*(size+LAT) : 0), "R6", "busy cycles", busy_cnt, ok ? N*(size+LAT) : 0);
        chk(exp_q.size() == 0, "R4", "writes not seen", exp_q.size(), 0);
        chk(bad_en_cnt == 0, "R7", "enables outside busy", bad_en_cnt, 0);
        chk(bad_rng_cnt == 0, "R9", "port accesses outside allowed compartments", bad_rng_cnt, 0);
        r4_bad = 0; r5_bad = 0;
        for (int m = 0; m < N; m++)
            for (int a = 0; a < DEPTH; a++)
                if (mem[m][a] !== exp_img[m][a]) begin
                    if (ok && a >= base && a < base + N*size &&
                        !(a >= base + m*size && a < base + (m+1)*size)) r4_bad++;
                    else r5_bad++;
                end
        chk(r4_bad == 0, "R4", "copied words wrong", r4_bad, 0);
        chk(r5_bad == 0, "R5", "untouched words changed", r5_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        cur_base = 0; cur_size = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held.
        chk(!busy && !done && !err && mem_en == '0, "R1", "outputs in reset",
            {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && mem_en == '0, "R1", "outputs after reset",
            {busy, done, err}, 0);
        run_xchg(5, 3, 1'b0, 1);     // R4 R5 R6: ordinary exchange
        run_xchg(0, 0, 1'b0, 2);     // R2: zero size rejected
        run_xchg(10, 20, 1'b0, 3);   // R3: overflow rejected
        run_xchg(0, 16, 1'b0, 4);    // R3: end exactly at depth accepted
        run_xchg(60, 1, 1'b0, 5);    // R3: one-word compartments at the top
        run_xchg(61, 1, 1'b0, 6);    // R3: one word past depth rejected
        run_xchg(2, 5, 1'b1, 7);     // R8: start while busy ignored
        summary();
        $finish;
    end

endmodule